// File: doc/BRIEF.md
# Shared-Port DShot Frame Generator

This block drives up to sixteen motor outputs that sit on one output port. All of them receive DShot frames at the same time. A free-running pacer divides the clock into sub-periods. For every sub-period of a frame, the block builds one atomic command word: the low half asks for pins to go high and the high half asks for pins to go low. The word is applied at once to a 16-bit output register, so every channel changes on the same clock edge. No per-channel PWM machinery is needed.

Each channel has a 16-bit packet and an enable bit in a channel mask. A start pulse, accepted only while the block is idle, captures all packets and the mask. The block then walks the sixteen packet bits of every channel in parallel, most significant bit first. Each bit spans twenty sub-periods. The frame closes with one trailing all-zero word, and a one-cycle completion pulse follows. The most recent command word is also presented at the ports, together with a strobe, so that neighbouring logic or a bench can follow the stream.

Top module: `dshot_port_gen`

## Requirements
- R1: During and right after reset, `pin_out`, `cmd_word`, `cmd_valid`, `busy` and `done` are all zero.
- R2: The pacer runs freely. Within a frame, consecutive `cmd_valid` strobes are exactly `TICK_DIV` clock cycles apart, which is 20 clocks by default.
- R3: A frame is exactly 321 command words. Word index 20*k+s carries sub-period s of packet bit 15-k, so the MSB goes first. Word 320 is all zero.
- R4: At sub-period 0 of every bit, bits [15:0] of the word equal the captured channel mask, and bits [31:16] are zero.
- R5: Bits [31:16] of a word are set for a channel in one of two places only: at sub-period 14 if the packet bit is 1, or at sub-period 7 if it is 0. Every other sub-period other than 0 gives an all-zero word.
- R6: A channel whose mask bit is clear never appears in either half of any word. With an all-zero mask, all 321 words are zero.
- R7: Each word updates the register as `pin_out = (pin_out & ~word[31:16]) | word[15:0]`. The new value is visible in the same cycle as its `cmd_valid`. A set request beats a reset request for the same pin.
- R8: Packets and mask are captured when start is accepted. Changes made to them during a frame do not affect that frame's words.
- R9: A start pulse that arrives while `busy` is high is ignored, and the running frame continues unchanged.
- R10: `done` is high for exactly one cycle, the same cycle as the `cmd_valid` of the trailing word. `busy` is low in that cycle.
- R11: A start pulse that arrives in the cycle `done` is high is accepted, and the next frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted when idle |
| pkt_flat | input | 256 | Channel c packet at bits [16c+15:16c] |
| chan_mask | input | 16 | Channel enable mask |
| pin_out | output | 16 | Output port register |
| cmd_word | output | 32 | Last applied command word, {reset, set} |
| cmd_valid | output | 1 | One-cycle strobe per applied word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Completion of one frame and acceptance of the next can fall in the same cycle. The bench provokes this by raising start in the very cycle it sees `done`, and then requires the next frame's 321 words to follow intact at the same pacer spacing. The completion pulse and the last word also share a cycle. The scoreboard judges this on every word it pops: `done` must be high exactly when the popped item is marked as the trailing word. A second case is a start request raised while a frame is running. The bench judges it by checking that the running frame's remaining words still match the expectations captured at the original start.

// File: rtl/dshot_port_pkg.sv
package dshot_port_pkg;
  localparam int unsigned NUM_CH     = 16;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned SUB_PER_BIT = 20;
  localparam int unsigned HI_ONE_END  = 14;
  localparam int unsigned HI_ZERO_END = 7;
  localparam int unsigned TICK_DIV    = 20;
endpackage

// File: rtl/dshot_pacer.sv
module dshot_pacer #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/dshot_frame_seq.sv
module dshot_frame_seq #(
  parameter int unsigned NCH  = 16,
  parameter int unsigned BITS = 16,
  parameter int unsigned SUBS = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  tick,
  input  logic [NCH*BITS-1:0]   pkt_in,
  input  logic [NCH-1:0]        mask_in,
  output logic [NCH*BITS-1:0]   pkt_lat,
  output logic [NCH-1:0]        mask_lat,
  output logic [$clog2(BITS)-1:0] bit_idx,
  output logic [$clog2(SUBS)-1:0] sub_idx,
  output logic                  trailing,
  output logic                  busy,
  output logic                  apply,
  output logic                  last
);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned SW = $clog2(SUBS);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);

  logic            busy_q, busy_d, trail_q, trail_d;
  logic [BW-1:0]   bit_q, bit_d;
  logic [SW-1:0]   sub_q, sub_d;
  logic            load;

  assign load  = start && !busy_q;
  assign apply = busy_q && tick;
  assign last  = apply && trail_q;

  always_comb begin
    busy_d  = busy_q;
    trail_d = trail_q;
    bit_d   = bit_q;
    sub_d   = sub_q;
    if (load) begin
      busy_d  = 1'b1;
      trail_d = 1'b0;
      bit_d   = '0;
      sub_d   = '0;
    end else if (apply) begin
      if (trail_q) begin
        busy_d  = 1'b0;
        trail_d = 1'b0;
      end else if (sub_q == SUB_LAST) begin
        sub_d = '0;
        if (bit_q == BIT_LAST) trail_d = 1'b1;
        else                   bit_d   = bit_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      trail_q <= 1'b0;
      bit_q   <= '0;
      sub_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      trail_q <= trail_d;
      bit_q   <= bit_d;
      sub_q   <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_lat  <= '0;
      mask_lat <= '0;
    end else if (load) begin
      pkt_lat  <= pkt_in;
      mask_lat <= mask_in;
    end
  end

  assign bit_idx  = bit_q;
  assign sub_idx  = sub_q;
  assign trailing = trail_q;
  assign busy     = busy_q;

  a_r3_sub_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_LAST);
  a_r3_trail_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sub_q == '0 && bit_q == BIT_LAST));
  a_r9_busy_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(pkt_lat) && $stable(mask_lat)));
endmodule

// File: rtl/dshot_word_comp.sv
module dshot_word_comp #(
  parameter int unsigned NCH  = 16,
  parameter int unsigned BITS = 16,
  parameter int unsigned SUBS = 20,
  parameter int unsigned T_ONE  = 14,
  parameter int unsigned T_ZERO = 7
) (
  input  logic [NCH*BITS-1:0]     pkt,
  input  logic [NCH-1:0]          mask,
  input  logic [$clog2(BITS)-1:0] bit_idx,
  input  logic [$clog2(SUBS)-1:0] sub_idx,
  input  logic                    trailing,
  output logic [2*NCH-1:0]        word
);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned SW = $clog2(SUBS);
  localparam logic [SW-1:0] S_ONE  = SW'(T_ONE);
  localparam logic [SW-1:0] S_ZERO = SW'(T_ZERO);
  localparam logic [BW-1:0] B_TOP  = BW'(BITS - 1);

  logic [BW-1:0] pos;
  logic          at_start;
  assign pos      = B_TOP - bit_idx;
  assign at_start = !trailing && (sub_idx == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [BITS-1:0] p;
    logic            val;
    assign p   = pkt[c*BITS +: BITS];
    assign val = p[pos];
    assign word[c]       = mask[c] && at_start;
    assign word[NCH + c] = mask[c] && !trailing &&
                           (sub_idx == (val ? S_ONE : S_ZERO));
  end
endmodule

// File: rtl/dshot_port_gen.sv
module dshot_port_gen
  import dshot_port_pkg::*;
#(
  parameter int unsigned NCH   = NUM_CH,
  parameter int unsigned BITS  = FRAME_BITS,
  parameter int unsigned SUBS  = SUB_PER_BIT,
  parameter int unsigned DIV   = TICK_DIV
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NCH*BITS-1:0]  pkt_flat,
  input  logic [NCH-1:0]       chan_mask,
  output logic [NCH-1:0]       pin_out,
  output logic [2*NCH-1:0]     cmd_word,
  output logic                 cmd_valid,
  output logic                 busy,
  output logic                 done
);
  localparam int unsigned BW = $clog2(BITS);
  localparam int unsigned SW = $clog2(SUBS);

  logic                tick, apply, last, trailing;
  logic [NCH*BITS-1:0] pkt_lat;
  logic [NCH-1:0]      mask_lat;
  logic [BW-1:0]       bit_idx;
  logic [SW-1:0]       sub_idx;
  logic [2*NCH-1:0]    word;

  dshot_pacer #(.DIV(DIV)) u_pacer (.clk(clk), .rst_n(rst_n), .tick(tick));

  dshot_frame_seq #(.NCH(NCH), .BITS(BITS), .SUBS(SUBS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .pkt_in(pkt_flat), .mask_in(chan_mask),
    .pkt_lat(pkt_lat), .mask_lat(mask_lat),
    .bit_idx(bit_idx), .sub_idx(sub_idx), .trailing(trailing),
    .busy(busy), .apply(apply), .last(last));

  dshot_word_comp #(.NCH(NCH), .BITS(BITS), .SUBS(SUBS),
                    .T_ONE(HI_ONE_END), .T_ZERO(HI_ZERO_END)) u_comp (
    .pkt(pkt_lat), .mask(mask_lat), .bit_idx(bit_idx), .sub_idx(sub_idx),
    .trailing(trailing), .word(word));

  logic [NCH-1:0]   pin_q, pin_d;
  logic [2*NCH-1:0] cmd_q, cmd_d;
  logic             val_q, done_q;

  always_comb begin
    pin_d = pin_q;
    cmd_d = cmd_q;
    if (apply) begin
      pin_d = (pin_q & ~word[2*NCH-1:NCH]) | word[NCH-1:0];
      cmd_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      cmd_q  <= '0;
      val_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pin_q  <= pin_d;
      cmd_q  <= cmd_d;
      val_q  <= apply;
      done_q <= last;
    end
  end

  assign pin_out   = pin_q;
  assign cmd_word  = cmd_q;
  assign cmd_valid = val_q;
  assign done      = done_q;

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((pin_out & cmd_word[NCH-1:0]) == cmd_word[NCH-1:0]));
  a_r6_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (((word[NCH-1:0] | word[2*NCH-1:NCH]) & ~mask_lat) == '0));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_valid && !busy && cmd_word == '0));
endmodule

// File: tb/tb_dshot_port_gen.sv
module tb_dshot_port_gen;
  localparam int NCH = 16;
  localparam int BITS = 16;
  localparam int SUBS = 20;
  localparam int DIV = 20;
  localparam int FRAME_WORDS = BITS*SUBS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NCH*BITS-1:0] pkt_flat = '0;
  logic [NCH-1:0] chan_mask = '0;
  logic [NCH-1:0] pin_out;
  logic [2*NCH-1:0] cmd_word;
  logic cmd_valid, busy, done;

  dshot_port_gen dut (.clk(clk), .rst_n(rst_n), .start(start), .pkt_flat(pkt_flat),
    .chan_mask(chan_mask), .pin_out(pin_out), .cmd_word(cmd_word),
    .cmd_valid(cmd_valid), .busy(busy), .done(done));

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  bit last_q[$];
  logic [NCH-1:0] model_pins = '0;
  int cyc = 0;
  int last_valid_cyc = -1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic push_frame(input logic [NCH*BITS-1:0] pk, input logic [NCH-1:0] m);
    for (int k = 0; k < BITS; k++) begin
      for (int s = 0; s < SUBS; s++) begin
        logic [31:0] w;
        w = '0;
        for (int c = 0; c < NCH; c++) begin
          logic b;
          b = pk[c*BITS + (BITS-1-k)];
          if (m[c] && s == 0) w[c] = 1'b1;
          if (m[c] && s == (b ? 14 : 7)) w[NCH+c] = 1'b1;
        end
        exp_q.push_back(w);
        last_q.push_back(1'b0);
      end
    end
    exp_q.push_back('0);
    last_q.push_back(1'b1);
  endtask

  task automatic fire(input logic [NCH*BITS-1:0] pk, input logic [NCH-1:0] m);
    @(negedge clk);
    while (busy) @(negedge clk);
    pkt_flat = pk; chan_mask = m; start = 1'b1;
    push_frame(pk, m);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cmd_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected word", cmd_word, 0);
        end else begin
          logic [31:0] e;
          bit l;
          e = exp_q.pop_front();
          l = last_q.pop_front();
          chk(cmd_word == e, "R3/R4/R5/R6/R8 word", cmd_word, e);
          model_pins = (model_pins & ~e[31:16]) | e[15:0];
          chk(pin_out == model_pins, "R7 pin_out", pin_out, model_pins);
          chk(done == l, "R10 done with trailing word", done, l);
          if (l) chk(busy == 1'b0, "R10 busy low at done", busy, 0);
          if (last_valid_cyc >= 0)
            chk(cyc - last_valid_cyc == DIV, "R2 tick spacing", cyc - last_valid_cyc, DIV);
          last_valid_cyc = l ? -1 : cyc;
        end
      end else begin
        if (done) chk(1'b0, "R10 done without word", done, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NCH*BITS-1:0] pa, pb, pc;
    for (int c = 0; c < NCH; c++) begin
      pa[c*BITS +: BITS] = 16'hA5C3 ^ 16'(c * 16'h1111);
      pb[c*BITS +: BITS] = 16'h3C96 + 16'(c * 16'h0F0F);
      pc[c*BITS +: BITS] = c[0] ? 16'hFFFF : 16'h0000;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pin_out == 0 && cmd_word == 0 && !cmd_valid && !busy && !done, "R1 reset outputs",
        {pin_out, cmd_word, cmd_valid, busy, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !cmd_valid && pin_out == 0, "R1 idle after reset", {busy, cmd_valid, pin_out}, 0);

    // frame 1: all channels enabled
    fire(pa, 16'hFFFF);
    repeat (DIV*40) @(negedge clk);
    // R8: change packets and mask mid-frame; R9: start while busy
    pkt_flat = ~pa; chan_mask = 16'h0F0F; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    // R11: restart in the done cycle
    while (!done) @(negedge clk);
    pkt_flat = pb; chan_mask = 16'h1C00; start = 1'b1;
    push_frame(pb, 16'h1C00);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R11 start accepted in done cycle", busy, 1);
    while (busy) @(negedge clk);

    // frame 3: no channels enabled (R6)
    repeat (37) @(negedge clk);
    fire(pa, 16'h0000);
    // frame 4: alternating all-ones / all-zeros packets, sparse mask
    fire(pc, 16'h00E5);
    while (busy || exp_q.size() != 0) @(negedge clk);
    repeat (3*DIV) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all words seen", exp_q.size(), 0);
    chk(!busy && !cmd_valid, "R10 idle after frames", {busy, cmd_valid}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule